// File: doc/BRIEF.md
# Packet Page Allocation Unit

This block keeps the bookkeeping for a small pool of fixed-size packet pages inside an Ethernet controller. It records which pages are in use and hands out the lowest free page on request. It also keeps three short ordered queues of page numbers: frames waiting to be sent, received frames waiting for software, and sent pages waiting for software to collect them. Software drives the block through a command byte, a packet-number register, an interrupt acknowledge write and an interrupt mask write. The receive path asks for pages through a request/grant port. The transmit path takes pages from the head of the transmit queue and reports each finished frame with a one-cycle pulse.

A transmit allocation that finds the pool full is not lost. The result reads as failed (0x80) and the request is retried in the same cycle that any page is released. When auto-release is on, a sent page returns to the pool at once. When it is off, the sent page goes onto the completion queue for software to collect. A four-bit interrupt status, a mask and a level interrupt output follow the queue state. The packet data memory and the MAC are outside this block.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset, int_status is 0x04, int_mask is 0, irq is low, alloc_result is 0, used_count is 0, tx_valid is low, and rx_head and done_head both read 0x80.
- R2: A command byte whose bits 7:5 are 001 (allocate) stores the lowest-numbered free page in alloc_result and marks that page used. On success it sets int_status bit 3.
- R3: An allocate command when all pages are used leaves alloc_result at 0x80 and clears int_status bit 3. While alloc_result reads 0x80, releasing a page retries the allocation in that same cycle: alloc_result becomes the freed page and bit 3 is set.
- R4: used_count always equals the number of pages marked used.
- R5: rx_grant is high when rx_req is high, a page is free, and no command or retried allocation occurs in that cycle. A granted request takes the lowest free page, appends it to the receive queue and sets int_status bit 0. rx_head reads 0x80 when the receive queue is empty.
- R6: Command 011 drops the receive-queue head without freeing it. Command 100 drops the head and frees its page. After either pop, int_status bit 0 stays set only if entries remain.
- R7: Command 110 appends the packet-number register value to the transmit queue. A push to a full queue is ignored. tx_valid/tx_page show the head, and each tx_sent pulse removes it, so pages leave in push order.
- R8: With auto_release high, a sent page is freed. With it low, the page is appended to the completion queue, whose head is done_head (0x80 when empty). int_status bit 1 is forced high while that queue is not empty.
- R9: int_status bit 2 is forced high while the transmit queue is empty.
- R10: An acknowledge write clears the status bits set in (ack_data AND 0xD6). When ack_data bit 1 is set, it also removes the completion-queue head.
- R11: irq is high exactly when (int_status AND int_mask) is nonzero.
- R12: Command 101 frees the page in the packet-number register. Command 010 frees every page, empties all three queues and sets alloc_result to 0. Command 111 empties only the transmit and completion queues. Command 000 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_wdata | input | 8 | Packet-number register write value |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_data | input | 8 | Acknowledge bit pattern |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | Interrupt mask value |
| auto_release | input | 1 | Free sent pages instead of queuing them |
| rx_req | input | 1 | Receive path requests a page |
| rx_grant | output | 1 | Page granted to the receive path this cycle |
| rx_page | output | 8 | Page number of the grant |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_page | output | 8 | Transmit queue head page |
| tx_sent | input | 1 | Head frame has been sent |
| alloc_result | output | 8 | Last allocate result, 0x80 on failure |
| rx_head | output | 8 | Receive queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| used_count | output | 8 | Number of used pages |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench fills the pool and then issues one more allocate, so that it can check that a release retries the stalled request in the same cycle. A design that dropped the retry would leave alloc_result at 0x80. It pushes a fifth page onto a full transmit queue and follows the send order, which catches a design that overwrote the tail or dropped the head. It acknowledges the transmit-done bit while the completion queue still holds entries, where a design that failed to force the bit would let it fall. It acknowledges the allocation bit, which lies outside the clear pattern, where a design that applied the pattern wrongly would clear it. It pops the receive queue down to empty and checks that the pop without release keeps the page counted as used.

// File: rtl/pau_pkg.sv
package pau_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_MMU_RST = 3'd2,
    CMD_RX_POP  = 3'd3,
    CMD_RX_FREE = 3'd4,
    CMD_REL     = 3'd5,
    CMD_TX_PUSH = 3'd6,
    CMD_TX_CLR  = 3'd7
  } pau_cmd_e;

  localparam logic [7:0] NONE_ID  = 8'h80;
  localparam logic [7:0] ACK_MASK = 8'hD6;

  localparam int INT_RX      = 0;
  localparam int INT_TXDONE  = 1;
  localparam int INT_TXEMPTY = 2;
  localparam int INT_ALLOC   = 3;

  // index of the lowest clear bit among the first n, or n when none is clear
  function automatic int lowest_clear(input logic [31:0] v, input int n);
    int r;
    r = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && !v[i]) r = i;
    end
    return r;
  endfunction

  function automatic int ones_count(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && v[i]) c++;
    end
    return c;
  endfunction

  function automatic logic [31:0] one_hot(input int idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/pau_id_queue.sv
module pau_id_queue #(
  parameter int DEPTH = 4,
  parameter int IDW   = 2,
  localparam int CTW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic           pop,
  output logic [IDW-1:0] head,
  output logic [CTW-1:0] count,
  output logic           empty,
  output logic           empty_nxt,
  output logic           full
);

  logic [IDW-1:0] ent_q   [DEPTH];
  logic [IDW-1:0] ent_nxt [DEPTH];
  logic [CTW-1:0] cnt_q, cnt_nxt, base;
  logic           pop_eff, push_eff;

  assign pop_eff  = pop && (cnt_q != '0);
  assign base     = cnt_q - CTW'(pop_eff);
  assign push_eff = push && (base < CTW'(DEPTH));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_eff && i < DEPTH - 1) ent_nxt[i] = ent_q[i+1];
      else                          ent_nxt[i] = ent_q[i];
    end
    if (push_eff) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CTW'(i) == base) ent_nxt[i] = push_id;
      end
    end
    cnt_nxt = clr ? '0 : base + CTW'(push_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_nxt[i];
    end
  end

  assign head      = ent_q[0];
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign empty_nxt = (cnt_nxt == '0);
  assign full      = (cnt_q == CTW'(DEPTH));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CTW'(DEPTH));

  // R7
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == CTW'(DEPTH)));

endmodule

// File: rtl/pau_page_pool.sv
module pau_page_pool
  import pau_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int IDW       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pool_clr,
  input  logic                 alloc_cmd,
  input  logic [NUM_PAGES-1:0] rel_vec,
  input  logic                 rx_req,
  input  logic                 rx_block,
  output logic                 rx_grant,
  output logic [IDW-1:0]       grant_id,
  output logic                 alloc_ok,
  output logic [7:0]           alloc_result,
  output logic [NUM_PAGES-1:0] used_mask,
  output logic [7:0]           used_count
);

  logic [NUM_PAGES-1:0] used_q, mask_a, used_nxt;
  logic [7:0]           res_q;
  logic                 pending, retry, attempt, avail;
  int                   pick;
  logic [31:0]          pick_oh;

  assign pending = (res_q == NONE_ID);
  assign retry   = pending && (|rel_vec);
  assign attempt = alloc_cmd || retry;
  assign mask_a  = used_q & ~rel_vec;
  assign pick    = lowest_clear(32'(mask_a), NUM_PAGES);
  assign avail   = (pick < NUM_PAGES);
  assign pick_oh = one_hot(pick);

  assign alloc_ok = attempt && avail && !pool_clr;
  assign rx_grant = rx_req && avail && !attempt && !rx_block && !pool_clr;
  assign grant_id = IDW'(pick);
  assign used_nxt = mask_a | ((alloc_ok || rx_grant) ? pick_oh[NUM_PAGES-1:0] : '0);

  always_ff @(posedge clk) begin
    if (!rst_n || pool_clr) begin
      used_q <= '0;
      res_q  <= '0;
    end else begin
      used_q <= used_nxt;
      if (attempt) res_q <= avail ? 8'(pick) : NONE_ID;
    end
  end

  assign alloc_result = res_q;
  assign used_mask    = used_q;
  assign used_count   = 8'(ones_count(32'(used_q), NUM_PAGES));

  // R2
  alloc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> (!alloc_result[7] && used_mask[alloc_result[IDW-1:0]]));

  // R3
  alloc_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_cmd && (&used_q) && (rel_vec == '0) && !pool_clr) |=> (alloc_result == NONE_ID));

  // R5
  rx_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_grant && !pool_clr) |=> used_mask[$past(grant_id)]);

endmodule

// File: rtl/pau_irq_ctrl.sv
module pau_irq_ctrl
  import pau_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_we,
  input  logic [7:0] ack_data,
  input  logic       mask_we,
  input  logic [7:0] mask_data,
  input  logic       alloc_clr,
  input  logic       alloc_set,
  input  logic       rx_set,
  input  logic       rx_pop,
  input  logic       rx_left,
  input  logic       txq_empty,
  input  logic       txq_empty_nxt,
  input  logic       cq_nonempty,
  input  logic       cq_nonempty_nxt,
  output logic [7:0] int_status,
  output logic [7:0] int_mask,
  output logic       irq
);

  logic [7:0] st_q, st_nxt, mk_q;

  always_comb begin
    st_nxt = st_q;
    if (ack_we)          st_nxt = st_nxt & ~(ack_data & ACK_MASK);
    if (alloc_clr)       st_nxt[INT_ALLOC]   = 1'b0;
    if (alloc_set)       st_nxt[INT_ALLOC]   = 1'b1;
    if (rx_pop)          st_nxt[INT_RX]      = rx_left;
    if (rx_set)          st_nxt[INT_RX]      = 1'b1;
    if (txq_empty_nxt)   st_nxt[INT_TXEMPTY] = 1'b1;
    if (cq_nonempty_nxt) st_nxt[INT_TXDONE]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 8'h04;
      mk_q <= 8'h00;
    end else begin
      st_q <= st_nxt;
      if (mask_we) mk_q <= mask_data;
    end
  end

  assign int_status = st_q;
  assign int_mask   = mk_q;
  assign irq        = |(st_q & mk_q);

  // R9
  txempty_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |-> int_status[INT_TXEMPTY]);

  // R8
  txdone_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_nonempty |-> int_status[INT_TXDONE]);

  // R10
  ack_keep_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !rx_set && !rx_pop) |=> (int_status[INT_RX] == $past(int_status[INT_RX])));

  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == 8'h00) |-> !irq);

endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import pau_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int IDW      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CTW      = $clog2(NUM_PAGES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       pnum_we,
  input  logic [7:0] pnum_wdata,
  input  logic       ack_we,
  input  logic [7:0] ack_data,
  input  logic       mask_we,
  input  logic [7:0] mask_data,
  input  logic       auto_release,
  input  logic       rx_req,
  output logic       rx_grant,
  output logic [7:0] rx_page,
  output logic       tx_valid,
  output logic [7:0] tx_page,
  input  logic       tx_sent,
  output logic [7:0] alloc_result,
  output logic [7:0] rx_head,
  output logic [7:0] done_head,
  output logic [7:0] used_count,
  output logic [7:0] int_status,
  output logic [7:0] int_mask,
  output logic       irq
);

  pau_cmd_e cmd;
  logic     c_alloc, c_mmu_rst, c_rx_pop, c_rx_free, c_rel, c_tx_push, c_tx_clr;
  logic [7:0] pnum_q;
  logic       pnum_ok;

  assign cmd       = pau_cmd_e'(cmd_byte[7:5]);
  assign c_alloc   = cmd_valid && (cmd == CMD_ALLOC);
  assign c_mmu_rst = cmd_valid && (cmd == CMD_MMU_RST);
  assign c_rx_pop  = cmd_valid && (cmd == CMD_RX_POP);
  assign c_rx_free = cmd_valid && (cmd == CMD_RX_FREE);
  assign c_rel     = cmd_valid && (cmd == CMD_REL);
  assign c_tx_push = cmd_valid && (cmd == CMD_TX_PUSH);
  assign c_tx_clr  = cmd_valid && (cmd == CMD_TX_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n)       pnum_q <= '0;
    else if (pnum_we) pnum_q <= pnum_wdata;
  end
  assign pnum_ok = (pnum_q < 8'(NUM_PAGES));

  // queue status
  logic [IDW-1:0] txq_head, rxq_head, cq_head, grant_id;
  logic [CTW-1:0] txq_cnt, rxq_cnt, cq_cnt;
  logic txq_empty, txq_empty_nxt, txq_full;
  logic rxq_empty, rxq_empty_nxt, rxq_full;
  logic cq_empty, cq_empty_nxt, cq_full;

  // events between the pieces
  logic sent_ev, sent_free, sent_park, cq_pop_ev, rx_pop_ev, q_tx_clr;
  logic alloc_ok;
  logic [NUM_PAGES-1:0] rel_vec, used_mask;
  logic [31:0] rel_w;

  assign sent_ev   = tx_sent && !txq_empty;
  assign sent_free = sent_ev && auto_release;
  assign sent_park = sent_ev && !auto_release;
  assign cq_pop_ev = ack_we && ack_data[INT_TXDONE];
  assign rx_pop_ev = c_rx_pop || c_rx_free;
  assign q_tx_clr  = c_mmu_rst || c_tx_clr;

  always_comb begin
    rel_w = '0;
    if (c_rel && pnum_ok)           rel_w = rel_w | one_hot(int'(pnum_q));
    if (c_rx_free && !rxq_empty)    rel_w = rel_w | one_hot(int'(rxq_head));
    if (sent_free)                  rel_w = rel_w | one_hot(int'(txq_head));
  end
  assign rel_vec = rel_w[NUM_PAGES-1:0];

  pau_page_pool #(.NUM_PAGES(NUM_PAGES), .IDW(IDW)) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .pool_clr     (c_mmu_rst),
    .alloc_cmd    (c_alloc),
    .rel_vec      (rel_vec),
    .rx_req       (rx_req),
    .rx_block     (cmd_valid),
    .rx_grant     (rx_grant),
    .grant_id     (grant_id),
    .alloc_ok     (alloc_ok),
    .alloc_result (alloc_result),
    .used_mask    (used_mask),
    .used_count   (used_count)
  );

  pau_id_queue #(.DEPTH(NUM_PAGES), .IDW(IDW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_tx_clr),
    .push      (c_tx_push && pnum_ok),
    .push_id   (pnum_q[IDW-1:0]),
    .pop       (sent_ev),
    .head      (txq_head),
    .count     (txq_cnt),
    .empty     (txq_empty),
    .empty_nxt (txq_empty_nxt),
    .full      (txq_full)
  );

  pau_id_queue #(.DEPTH(NUM_PAGES), .IDW(IDW)) u_cq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_tx_clr),
    .push      (sent_park),
    .push_id   (txq_head),
    .pop       (cq_pop_ev),
    .head      (cq_head),
    .count     (cq_cnt),
    .empty     (cq_empty),
    .empty_nxt (cq_empty_nxt),
    .full      (cq_full)
  );

  pau_id_queue #(.DEPTH(NUM_PAGES), .IDW(IDW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (c_mmu_rst),
    .push      (rx_grant),
    .push_id   (grant_id),
    .pop       (rx_pop_ev),
    .head      (rxq_head),
    .count     (rxq_cnt),
    .empty     (rxq_empty),
    .empty_nxt (rxq_empty_nxt),
    .full      (rxq_full)
  );

  pau_irq_ctrl u_irq (
    .clk             (clk),
    .rst_n           (rst_n),
    .ack_we          (ack_we),
    .ack_data        (ack_data),
    .mask_we         (mask_we),
    .mask_data       (mask_data),
    .alloc_clr       (c_alloc),
    .alloc_set       (alloc_ok),
    .rx_set          (rx_grant),
    .rx_pop          (rx_pop_ev),
    .rx_left         (!rxq_empty_nxt),
    .txq_empty       (txq_empty),
    .txq_empty_nxt   (txq_empty_nxt),
    .cq_nonempty     (!cq_empty),
    .cq_nonempty_nxt (!cq_empty_nxt),
    .int_status      (int_status),
    .int_mask        (int_mask),
    .irq             (irq)
  );

  assign rx_page   = 8'(grant_id);
  assign tx_valid  = !txq_empty;
  assign tx_page   = 8'(txq_head);
  assign rx_head   = rxq_empty ? NONE_ID : 8'(rxq_head);
  assign done_head = cq_empty  ? NONE_ID : 8'(cq_head);

  // R5
  rx_enqueue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |=> (rx_head != NONE_ID));

  // R12
  mmu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_mmu_rst |=> (used_count == 8'd0 && rx_head == NONE_ID && !tx_valid));

  // R8
  auto_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_free && !c_mmu_rst && !c_tx_clr && !cq_pop_ev) |=> $stable(done_head));

endmodule

// File: tb/tb_pkt_page_mmu.sv
module tb_pkt_page_mmu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, pnum_we, ack_we, mask_we, auto_release, rx_req, tx_sent;
  logic [7:0] cmd_byte, pnum_wdata, ack_data, mask_data;
  logic       rx_grant, tx_valid, irq;
  logic [7:0] rx_page, tx_page, alloc_result, rx_head, done_head, used_count, int_status, int_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pkt_page_mmu dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pnum_we(pnum_we), .pnum_wdata(pnum_wdata), .ack_we(ack_we), .ack_data(ack_data),
    .mask_we(mask_we), .mask_data(mask_data), .auto_release(auto_release),
    .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page), .tx_valid(tx_valid),
    .tx_page(tx_page), .tx_sent(tx_sent), .alloc_result(alloc_result), .rx_head(rx_head),
    .done_head(done_head), .used_count(used_count), .int_status(int_status),
    .int_mask(int_mask), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] code);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = {code, 5'b0};
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic set_pn(input logic [7:0] v);
    @(negedge clk); pnum_we = 1'b1; pnum_wdata = v;
    @(negedge clk); pnum_we = 1'b0;
  endtask
  task automatic do_ack(input logic [7:0] v);
    @(negedge clk); ack_we = 1'b1; ack_data = v;
    @(negedge clk); ack_we = 1'b0;
  endtask
  task automatic set_mask(input logic [7:0] v);
    @(negedge clk); mask_we = 1'b1; mask_data = v;
    @(negedge clk); mask_we = 1'b0;
  endtask
  task automatic do_send();
    @(negedge clk); tx_sent = 1'b1;
    @(negedge clk); tx_sent = 1'b0;
  endtask
  task automatic do_rx(output logic g, output logic [7:0] pg);
    @(negedge clk); rx_req = 1'b1; #1; g = rx_grant; pg = rx_page;
    @(negedge clk); rx_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", int_status, 8'h04);
    chk("R1 mask", int_mask, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 result", alloc_result, 8'h00);
    chk("R1 used", used_count, 8'h00);
    chk("R1 rx_head", rx_head, 8'h80);
    chk("R1 done_head", done_head, 8'h80);
    chk("R9 txvalid", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_alloc();
    for (int i = 0; i < 4; i++) begin
      do_cmd(3'b001);
      chk("R2 lowest page", alloc_result, 8'(i));
      chk("R4 count", used_count, 8'(i + 1));
    end
    chk("R2 alloc bit", int_status & 8'h08, 8'h08);
    do_cmd(3'b001);
    chk("R3 full result", alloc_result, 8'h80);
    chk("R3 alloc bit cleared", int_status & 8'h08, 8'h00);
    set_pn(8'd2);
    do_cmd(3'b101);
    chk("R3 retry result", alloc_result, 8'h02);
    chk("R3 retry bit", int_status & 8'h08, 8'h08);
    chk("R4 count after retry", used_count, 8'd4);
    do_cmd(3'b010);
    chk("R12 mmu reset used", used_count, 8'd0);
    chk("R12 mmu reset result", alloc_result, 8'h00);
  endtask

  task automatic t_rx();
    logic g;
    logic [7:0] pg;
    @(negedge clk); rx_req = 1'b1; cmd_valid = 1'b1; cmd_byte = 8'h00; #1;
    chk("R5 blocked by cmd", {7'b0, rx_grant}, 8'h00);
    @(negedge clk); rx_req = 1'b0; cmd_valid = 1'b0;
    chk("R5 empty head", rx_head, 8'h80);
    do_rx(g, pg);
    chk("R5 grant", {7'b0, g}, 8'h01);
    chk("R5 page0", pg, 8'h00);
    do_rx(g, pg);
    chk("R5 page1", pg, 8'h01);
    chk("R5 head", rx_head, 8'h00);
    chk("R5 rx bit", int_status & 8'h01, 8'h01);
    do_cmd(3'b001);
    chk("R2 after rx", alloc_result, 8'h02);
    do_cmd(3'b011);
    chk("R6 pop head", rx_head, 8'h01);
    chk("R6 bit kept", int_status & 8'h01, 8'h01);
    chk("R6 no release", used_count, 8'd3);
    do_cmd(3'b100);
    chk("R6 pop empty", rx_head, 8'h80);
    chk("R6 bit cleared", int_status & 8'h01, 8'h00);
    chk("R6 released", used_count, 8'd2);
    do_cmd(3'b001);
    chk("R2 refill hole", alloc_result, 8'h01);
    do_cmd(3'b010);
  endtask

  task automatic t_tx();
    for (int i = 0; i < 3; i++) do_cmd(3'b001);
    set_pn(8'd0); do_cmd(3'b110);
    chk("R7 head", tx_page, 8'h00);
    chk("R7 valid", {7'b0, tx_valid}, 8'h01);
    do_ack(8'h04);
    chk("R10 ack txempty", int_status, 8'h08);
    set_pn(8'd1); do_cmd(3'b110);
    set_pn(8'd2); do_cmd(3'b110);
    set_pn(8'd1); do_cmd(3'b110);
    set_pn(8'd2); do_cmd(3'b110);
    do_send();
    chk("R7 second head", tx_page, 8'h01);
    chk("R8 done head", done_head, 8'h00);
    chk("R8 done bit", int_status, 8'h0A);
    chk("R8 not freed", used_count, 8'd3);
    do_send();
    chk("R7 third head", tx_page, 8'h02);
    do_send();
    chk("R7 fourth head", tx_page, 8'h01);
    do_send();
    chk("R7 full push ignored", {7'b0, tx_valid}, 8'h00);
    chk("R9 txempty forced", int_status, 8'h0E);
    do_ack(8'h02);
    chk("R10 pop done", done_head, 8'h01);
    chk("R10 bit reforced", int_status, 8'h0E);
    set_mask(8'h02);
    chk("R11 irq on", {7'b0, irq}, 8'h01);
    set_mask(8'h01);
    chk("R11 irq off", {7'b0, irq}, 8'h00);
    do_cmd(3'b111);
    chk("R12 tx clear done", done_head, 8'h80);
    chk("R12 tx clear keeps pool", used_count, 8'd3);
    do_ack(8'h02);
    chk("R8 bit drops", int_status, 8'h0C);
    do_ack(8'h08);
    chk("R10 alloc bit kept", int_status, 8'h0C);
    do_cmd(3'b000);
    chk("R12 noop status", int_status, 8'h0C);
    chk("R12 noop used", used_count, 8'd3);
    @(negedge clk); auto_release = 1'b1;
    set_pn(8'd1); do_cmd(3'b110);
    do_send();
    chk("R8 auto freed", used_count, 8'd2);
    chk("R8 auto no queue", done_head, 8'h80);
    do_cmd(3'b001);
    chk("R2 freed page reused", alloc_result, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_byte = 0; pnum_we = 0; pnum_wdata = 0;
    ack_we = 0; ack_data = 0; mask_we = 0; mask_data = 0; auto_release = 0;
    rx_req = 0; tx_sent = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_rx();
    t_tx();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule